// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gating

This block sits between the clock sources of a system clock generator and its output pins. It gates four groups of clock copies: processor, memory, interrupt-controller and PCI. Each group has one free-running copy and a parameterised number of stoppable copies. A power-management clock-stop input halts the stoppable copies of the processor, memory and interrupt groups. A separate PCI-stop input, sampled on the PCI source clock, halts only the stoppable PCI copies. A per-copy enable bit parks any single copy at logic 0 while it keeps driving. A global high-impedance control releases every output-enable at once.

The stop inputs and the enable bits are asynchronous to the clocks they act on. Each group brings them through its own two-flop synchroniser, clocked by its source clock. A flop on the falling source edge then holds each copy's gate enable. The gate changes only while the source is low, so every pulse that leaves the block is a full source high phase. A stop takes effect after the pulse in flight has finished, and a restart begins with a whole pulse. Clock synthesis and the pad buffers are outside this block.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_ni` is low, every clock output of every group is low, whatever the stop and enable inputs are. The output-enables still follow `hiz_i`.
- R2: In the processor, memory and interrupt groups, stoppable copy j pulses on source rising edge k only if `clk_stop_ni` and enable bit j+1 were both high when sampled at rising edge k-2. Otherwise it stays low for that cycle. A stop therefore lets the pulse in flight finish and acts 2 to 3 source cycles after the request.
- R3: Every output high phase, free-running or stoppable, covers exactly one whole source high phase, and every output is low during the source low phase. No pulse is shortened, and after a stop the first pulse is complete.
- R4: The free-running copy of each group, controlled by enable bit 0, ignores both stop inputs. It pulses on rising edge k only if its bit 0 was high at edge k-2.
- R5: `pci_stop_ni` is sampled on rising edges of `pci_clk_i` and follows the same two-edge rule for the stoppable PCI copies only. `clk_stop_ni` has no effect on the PCI group, and `pci_stop_ni` has no effect on the other three groups.
- R6: Within each enable vector, bit 0 belongs to the free copy and bit i (i ≥ 1) belongs to stoppable copy i-1. A bit at 0 holds its copy low with the same two-edge latency, while that copy's output-enable stays high.
- R7: With `hiz_i` high, every output-enable bit of every group is low with no clock delay. With `hiz_i` low, they are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset, released per group on its source clock |
| cpu_clk_i | input | 1 | Processor group source clock |
| mem_clk_i | input | 1 | Memory group source clock |
| irq_clk_i | input | 1 | Interrupt-controller group source clock |
| pci_clk_i | input | 1 | PCI group source clock |
| clk_stop_ni | input | 1 | Active-low stop for processor, memory and interrupt stoppable copies |
| pci_stop_ni | input | 1 | Active-low stop for the PCI stoppable copies |
| hiz_i | input | 1 | Global high-impedance control, drops all output-enables |
| cpu_en_i | input | N_CPU+1 (3) | Processor enables: bit 0 free copy, bit i copy i-1 |
| mem_en_i | input | N_MEM+1 (17) | Memory enables, same layout |
| irq_en_i | input | N_IRQ+1 (2) | Interrupt-controller enables, same layout |
| pci_en_i | input | N_PCI+1 (7) | PCI enables, same layout |
| cpu_free_o | output | 1 | Free-running processor clock |
| cpu_gated_o | output | N_CPU (2) | Stoppable processor clocks |
| cpu_oe_o | output | N_CPU+1 (3) | Processor output-enables, bit layout as the enables |
| mem_free_o | output | 1 | Free-running memory clock |
| mem_gated_o | output | N_MEM (16) | Stoppable memory clocks |
| mem_oe_o | output | N_MEM+1 (17) | Memory output-enables |
| irq_free_o | output | 1 | Free-running interrupt-controller clock |
| irq_gated_o | output | N_IRQ (1) | Stoppable interrupt-controller clocks |
| irq_oe_o | output | N_IRQ+1 (2) | Interrupt-controller output-enables |
| pci_free_o | output | 1 | Free-running PCI clock |
| pci_gated_o | output | N_PCI (6) | Stoppable PCI clocks |
| pci_oe_o | output | N_PCI+1 (7) | PCI output-enables |

## Verification
A stop transition and a change of a copy's enable bit can reach the same sampling edge. The block must then combine both from that single sample, with no copy seeing one a cycle before the other. The bench provokes this by changing `clk_stop_ni` and several enable bits in the same instant, both when stopping and when restarting. Its model keeps, per group, a queue of the stop-and-enable word sampled at each source rising edge and predicts every copy from the entry two edges old. The outputs are judged early and late in each high phase and in each low phase, so a runt or a one-cycle skew between the two causes is seen.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  // depth of every asynchronous-input and reset-release synchroniser
  localparam int unsigned SYNC_STAGES = 2;

  // state of one copy's gate, updated on the falling source edge
  typedef enum logic {
    GATE_OFF = 1'b0,
    GATE_RUN = 1'b1
  } gate_e;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = clkstop_pkg::SYNC_STAGES,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/clkstop_cell.sv
module clkstop_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o,
  output logic en_o
);
  import clkstop_pkg::*;

  gate_e state_q;
  gate_e state_d;

  always_comb begin
    state_d = run_i ? GATE_RUN : GATE_OFF;
  end

  // falling-edge update: the gate moves only while the source is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GATE_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  assign en_o  = (state_q == GATE_RUN);
  assign clk_o = clk_i & en_o;

endmodule

// File: rtl/clkstop_group.sv
module clkstop_group #(
  parameter int unsigned N_GATED = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_ni,
  input  logic             hiz_i,
  input  logic [N_GATED:0] en_i,
  output logic             free_o,
  output logic [N_GATED-1:0] gated_o,
  output logic [N_GATED:0] oe_o
);

  localparam int unsigned W  = N_GATED + 1;
  localparam int unsigned SW = W + 1;

  logic          rst_s;
  logic [SW-1:0] sync_q;
  logic          stop_s;
  logic [W-1:0]  en_s;
  logic [W-1:0]  run;
  logic [W-1:0]  clk_vec;
  logic [W-1:0]  en_q;

  // reset release aligned to this group's source clock
  clkstop_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_s)
  );

  // stop request and enable bits share one synchroniser
  clkstop_sync #(.W(SW), .RST_VAL('0)) u_in_sync (
    .clk_i (clk_i),
    .rst_ni(rst_s),
    .d_i   ({stop_ni, en_i}),
    .q_o   (sync_q)
  );

  assign stop_s = sync_q[SW-1];
  assign en_s   = sync_q[W-1:0];

  always_comb begin
    run[0] = en_s[0];
    for (int i = 1; i < W; i++) begin
      run[i] = en_s[i] & stop_s;
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_copy
    clkstop_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_s),
      .run_i (run[g]),
      .clk_o (clk_vec[g]),
      .en_o  (en_q[g])
    );
  end

  assign free_o  = clk_vec[0];
  assign gated_o = clk_vec[W-1:1];
  assign oe_o    = {W{~hiz_i}};

  // cycles since reset release, so that two-deep history is valid
  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      age_q <= '0;
    end else begin
      age_q <= {age_q[1:0], 1'b1};
    end
  end

  // R2
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!age_q[2])
    !$past(stop_ni, 2) |-> (en_q[W-1:1] == '0));

  // R3
  restart_chk: assert property (@(posedge clk_i) disable iff (!age_q[2])
    $past(stop_ni, 2) |-> (en_q[W-1:1] == $past(en_i[W-1:1], 2)));

  // R4
  free_run_chk: assert property (@(posedge clk_i) disable iff (!age_q[2])
    1'b1 |-> (en_q[0] == $past(en_i[0], 2)));

  // R6
  disable_low_chk: assert property (@(posedge clk_i) disable iff (!age_q[2])
    1'b1 |-> ((en_q & ~$past(en_i, 2)) == '0));

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int unsigned N_CPU = 2,
  parameter int unsigned N_MEM = 16,
  parameter int unsigned N_IRQ = 1,
  parameter int unsigned N_PCI = 6
) (
  input  logic             rst_ni,
  input  logic             cpu_clk_i,
  input  logic             mem_clk_i,
  input  logic             irq_clk_i,
  input  logic             pci_clk_i,
  input  logic             clk_stop_ni,
  input  logic             pci_stop_ni,
  input  logic             hiz_i,
  input  logic [N_CPU:0]   cpu_en_i,
  input  logic [N_MEM:0]   mem_en_i,
  input  logic [N_IRQ:0]   irq_en_i,
  input  logic [N_PCI:0]   pci_en_i,
  output logic             cpu_free_o,
  output logic [N_CPU-1:0] cpu_gated_o,
  output logic [N_CPU:0]   cpu_oe_o,
  output logic             mem_free_o,
  output logic [N_MEM-1:0] mem_gated_o,
  output logic [N_MEM:0]   mem_oe_o,
  output logic             irq_free_o,
  output logic [N_IRQ-1:0] irq_gated_o,
  output logic [N_IRQ:0]   irq_oe_o,
  output logic             pci_free_o,
  output logic [N_PCI-1:0] pci_gated_o,
  output logic [N_PCI:0]   pci_oe_o
);

  clkstop_group #(.N_GATED(N_CPU)) u_cpu (
    .clk_i  (cpu_clk_i),
    .rst_ni (rst_ni),
    .stop_ni(clk_stop_ni),
    .hiz_i  (hiz_i),
    .en_i   (cpu_en_i),
    .free_o (cpu_free_o),
    .gated_o(cpu_gated_o),
    .oe_o   (cpu_oe_o)
  );

  clkstop_group #(.N_GATED(N_MEM)) u_mem (
    .clk_i  (mem_clk_i),
    .rst_ni (rst_ni),
    .stop_ni(clk_stop_ni),
    .hiz_i  (hiz_i),
    .en_i   (mem_en_i),
    .free_o (mem_free_o),
    .gated_o(mem_gated_o),
    .oe_o   (mem_oe_o)
  );

  clkstop_group #(.N_GATED(N_IRQ)) u_irq (
    .clk_i  (irq_clk_i),
    .rst_ni (rst_ni),
    .stop_ni(clk_stop_ni),
    .hiz_i  (hiz_i),
    .en_i   (irq_en_i),
    .free_o (irq_free_o),
    .gated_o(irq_gated_o),
    .oe_o   (irq_oe_o)
  );

  // PCI copies answer only to their own stop, in their own domain
  clkstop_group #(.N_GATED(N_PCI)) u_pci (
    .clk_i  (pci_clk_i),
    .rst_ni (rst_ni),
    .stop_ni(pci_stop_ni),
    .hiz_i  (hiz_i),
    .en_i   (pci_en_i),
    .free_o (pci_free_o),
    .gated_o(pci_gated_o),
    .oe_o   (pci_oe_o)
  );

endmodule

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/100ps

module sim_ref_group #(
  parameter int    N    = 2,
  parameter int    HALF = 5,
  parameter string GREQ = "R2",
  parameter string TAG  = "cpu"
) (
  input  logic       clk,
  input  logic       stop_n,
  input  logic       hiz,
  input  logic       armed,
  input  logic [N:0] en,
  input  logic       free,
  input  logic [N-1:0] gated,
  input  logic [N:0] oe,
  output int         checks,
  output int         errs
);
  logic [N:0] hist[$];
  int ca = 0, ea = 0, cb = 0, eb = 0;

  assign checks = ca + cb;
  assign errs   = ea + eb;

  always @(posedge clk) begin
    logic [N:0] smp;
    logic [N:0] exp_w;
    smp = en & {{N{stop_n}}, 1'b1};
    hist.push_back(smp);
    if (hist.size() > 3) void'(hist.pop_front());
    #1;
    if (armed && hist.size() == 3) begin
      exp_w = hist[0];
      ca++;
      if (free !== exp_w[0]) begin
        ea++;
        $display("FAIL R4 %s free actual=%b expected=%b t=%0t", TAG, free, exp_w[0], $time);
      end
      ca++;
      if (gated !== exp_w[N:1]) begin
        ea++;
        $display("FAIL %s %s gated actual=%b expected=%b t=%0t", GREQ, TAG, gated, exp_w[N:1], $time);
      end
      ca++;
      if (oe !== {(N+1){~hiz}}) begin
        ea++;
        $display("FAIL R7 %s oe actual=%b expected=%b t=%0t", TAG, oe, {(N+1){~hiz}}, $time);
      end
      #(HALF-2);
      ca++;
      if ({gated, free} !== exp_w) begin
        ea++;
        $display("FAIL R3 %s late-high actual=%b expected=%b t=%0t", TAG, {gated, free}, exp_w, $time);
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (armed) begin
      cb++;
      if ({gated, free} !== '0) begin
        eb++;
        $display("FAIL R3 %s low-phase actual=%b expected=0 t=%0t", TAG, {gated, free}, $time);
      end
    end
  end
endmodule

module sim_clk_stop_gate;
  localparam int N_CPU = 2, N_MEM = 16, N_IRQ = 1, N_PCI = 6;

  logic rst_n = 1'b0;
  logic cpu_clk = 1'b0, mem_clk = 1'b0, irq_clk = 1'b0, pci_clk = 1'b0;
  logic clk_stop_n = 1'b1, pci_stop_n = 1'b1, hiz = 1'b0, armed = 1'b0;
  logic [N_CPU:0] cpu_en = '1;
  logic [N_MEM:0] mem_en = '1;
  logic [N_IRQ:0] irq_en = '1;
  logic [N_PCI:0] pci_en = '1;
  logic cpu_free, mem_free, irq_free, pci_free;
  logic [N_CPU-1:0] cpu_gated;
  logic [N_MEM-1:0] mem_gated;
  logic [N_IRQ-1:0] irq_gated;
  logic [N_PCI-1:0] pci_gated;
  logic [N_CPU:0] cpu_oe;
  logic [N_MEM:0] mem_oe;
  logic [N_IRQ:0] irq_oe;
  logic [N_PCI:0] pci_oe;

  int checks = 0, errors = 0;
  int c_cpu, e_cpu, c_mem, e_mem, c_irq, e_irq, c_pci, e_pci;

  always #5  cpu_clk = ~cpu_clk;  // 100 MHz
  always #4  mem_clk = ~mem_clk;
  always #7  irq_clk = ~irq_clk;
  always #15 pci_clk = ~pci_clk;

  clk_stop_gate #(.N_CPU(N_CPU), .N_MEM(N_MEM), .N_IRQ(N_IRQ), .N_PCI(N_PCI)) u0 (
    .rst_ni(rst_n), .cpu_clk_i(cpu_clk), .mem_clk_i(mem_clk), .irq_clk_i(irq_clk),
    .pci_clk_i(pci_clk), .clk_stop_ni(clk_stop_n), .pci_stop_ni(pci_stop_n), .hiz_i(hiz),
    .cpu_en_i(cpu_en), .mem_en_i(mem_en), .irq_en_i(irq_en), .pci_en_i(pci_en),
    .cpu_free_o(cpu_free), .cpu_gated_o(cpu_gated), .cpu_oe_o(cpu_oe),
    .mem_free_o(mem_free), .mem_gated_o(mem_gated), .mem_oe_o(mem_oe),
    .irq_free_o(irq_free), .irq_gated_o(irq_gated), .irq_oe_o(irq_oe),
    .pci_free_o(pci_free), .pci_gated_o(pci_gated), .pci_oe_o(pci_oe)
  );

  sim_ref_group #(.N(N_CPU), .HALF(5), .GREQ("R2"), .TAG("cpu")) ref_cpu (
    .clk(cpu_clk), .stop_n(clk_stop_n), .hiz(hiz), .armed(armed), .en(cpu_en),
    .free(cpu_free), .gated(cpu_gated), .oe(cpu_oe), .checks(c_cpu), .errs(e_cpu));
  sim_ref_group #(.N(N_MEM), .HALF(4), .GREQ("R2"), .TAG("mem")) ref_mem (
    .clk(mem_clk), .stop_n(clk_stop_n), .hiz(hiz), .armed(armed), .en(mem_en),
    .free(mem_free), .gated(mem_gated), .oe(mem_oe), .checks(c_mem), .errs(e_mem));
  sim_ref_group #(.N(N_IRQ), .HALF(7), .GREQ("R2"), .TAG("irq")) ref_irq (
    .clk(irq_clk), .stop_n(clk_stop_n), .hiz(hiz), .armed(armed), .en(irq_en),
    .free(irq_free), .gated(irq_gated), .oe(irq_oe), .checks(c_irq), .errs(e_irq));
  sim_ref_group #(.N(N_PCI), .HALF(15), .GREQ("R5"), .TAG("pci")) ref_pci (
    .clk(pci_clk), .stop_n(pci_stop_n), .hiz(hiz), .armed(armed), .en(pci_en),
    .free(pci_free), .gated(pci_gated), .oe(pci_oe), .checks(c_pci), .errs(e_pci));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp_v, $time);
    end
  endtask

  // move to an instant that no clock edge of any group can share
  task automatic align();
    @(posedge cpu_clk);
    #2.3;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors",
             checks + c_cpu + c_mem + c_irq + c_pci,
             errors + e_cpu + e_mem + e_irq + e_pci);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired t=%0t", $time);
    summary();
  end

  initial begin
    // R1: outputs low throughout reset, enables follow hiz
    for (int i = 0; i < 4; i++) begin
      @(posedge cpu_clk); #1;
      chk("R1 cpu/irq clocks in reset", {29'd0, cpu_gated, cpu_free}, 32'd0);
      chk("R1 mem clocks in reset", {15'd0, mem_gated, mem_free}, 32'd0);
      chk("R1 oe in reset", {29'd0, cpu_oe}, 32'd7);
    end
    @(posedge pci_clk); #1;
    chk("R1 pci clocks in reset", {25'd0, pci_gated, pci_free}, 32'd0);
    chk("R1 irq clocks in reset", {30'd0, irq_gated, irq_free}, 32'd0);
    align();
    rst_n = 1'b1;
    #400;
    armed = 1'b1;
    #300;

    // R2 and R4: clock stop, free copies keep running
    align();
    clk_stop_n = 1'b0;
    #300;
    @(posedge cpu_clk); #1;
    chk("R4 cpu free during clock stop", {31'd0, cpu_free}, 32'd1);
    chk("R2 cpu gated held low", {30'd0, cpu_gated}, 32'd0);
    @(posedge pci_clk); #1;
    chk("R5 pci gated ignore clock stop", {26'd0, pci_gated}, 32'h3f);
    align();
    clk_stop_n = 1'b1;
    #300;

    // R5: PCI stop only acts on the PCI copies
    align();
    pci_stop_n = 1'b0;
    #400;
    @(posedge pci_clk); #1;
    chk("R5 pci gated held low", {26'd0, pci_gated}, 32'd0);
    chk("R5 pci free runs", {31'd0, pci_free}, 32'd1);
    @(posedge cpu_clk); #1;
    chk("R5 cpu unaffected by pci stop", {30'd0, cpu_gated}, 32'd3);
    align();
    pci_stop_n = 1'b1;
    #300;

    // R6: single disable bits, including a free copy
    align();
    mem_en[5] = 1'b0;
    irq_en[0] = 1'b0;
    #300;
    @(posedge mem_clk); #1;
    chk("R6 mem copy 4 parked low", {31'd0, mem_gated[4]}, 32'd0);
    chk("R6 mem copy 4 still driven", {31'd0, mem_oe[5]}, 32'd1);
    chk("R6 mem copy 3 running", {31'd0, mem_gated[3]}, 32'd1);
    @(posedge irq_clk); #1;
    chk("R6 irq free parked low", {31'd0, irq_free}, 32'd0);

    // same instant: stop edge and enable changes
    align();
    clk_stop_n = 1'b0;
    mem_en[5]  = 1'b1;
    cpu_en[2]  = 1'b0;
    irq_en[0]  = 1'b1;
    #300;
    align();
    clk_stop_n = 1'b1;
    cpu_en[2]  = 1'b1;
    mem_en[0]  = 1'b0;
    #300;
    @(posedge cpu_clk); #1;
    chk("R3 cpu restarted", {30'd0, cpu_gated}, 32'd3);
    align();
    mem_en[0] = 1'b1;

    // R7: high impedance at once
    align();
    hiz = 1'b1;
    #0.5;
    chk("R7 cpu oe dropped", {29'd0, cpu_oe}, 32'd0);
    chk("R7 mem oe dropped", {15'd0, mem_oe}, 32'd0);
    chk("R7 pci oe dropped", {25'd0, pci_oe}, 32'd0);
    #200;
    hiz = 1'b0;
    #0.5;
    chk("R7 irq oe restored", {30'd0, irq_oe}, 32'd3);

    // short stop pulses and irregular PCI stop toggling
    align();
    clk_stop_n = 1'b0;
    #3;
    clk_stop_n = 1'b1;
    #40;
    clk_stop_n = 1'b0;
    #12;
    clk_stop_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #(7 + 3 * i);
      pci_stop_n = ~pci_stop_n;
      clk_stop_n = ~clk_stop_n;
    end
    pci_stop_n = 1'b1;
    clk_stop_n = 1'b1;
    #400;

    armed = 1'b0;
    #40;
    summary();
  end
endmodule